// File: doc/BRIEF.md
# Radix page table walker

This block translates a 64-bit effective address into a real address by walking a multi-level radix tree in memory. A one-cycle start pulse captures four values: the page-number part of the effective address, the process ID, and the base and size fields of the process table register. The walker then reads one 8-byte process table entry. That entry gives the tree's total size, the size of the root directory and the root base.

After a segment check, the walker descends one directory level per memory read. At each level it merges the index bits of the effective address into that level's base to form the entry address. A valid non-leaf entry supplies the next level's base and index width, and each such level consumes part of a working shift. A leaf entry ends the walk. The walk finishes with a one-cycle done pulse that carries either success, with the real address and the leaf entry, or exactly one of three errors: segment, invalid entry or bad tree.

Memory is reached through a plain request/acknowledge port. At most one 8-byte read is outstanding, and the walker holds it until the acknowledge arrives. Entries are taken as 64-bit words exactly as read, with no byte reordering. Bit 63 of the word is the valid flag and bit 62 is the leaf flag.

States: IDLE, PRTBL_READ, SEG_CHECK, LOOKUP, WAIT_MEM and FINISH. The transitions are:
- IDLE→PRTBL_READ on start.
- PRTBL_READ→WAIT_MEM, issuing the table read.
- WAIT_MEM→SEG_CHECK when the table entry returns.
- SEG_CHECK→LOOKUP when the address and root size are good, or SEG_CHECK→FINISH on a fault.
- LOOKUP→WAIT_MEM, issuing a directory read.
- WAIT_MEM→LOOKUP on a good non-leaf entry.
- WAIT_MEM→FINISH on a leaf, an invalid entry or a bad size.
- FINISH→IDLE.

Top module: `rwalk_top`

## Requirements
- R1: The process table entry address is {8'h00, base[43:24], (base[23:0] & ~m) | (epid[31:8] & m), epid[7:0], 4'b0000}. Here base is the ptab_base input (table register bits 55:12) and m is a 24-bit mask whose low ptab_size bits are ones.
- R2: The effective PID epid is zero when effective address bit 63 is 1, and is the pid input otherwise.
- R3: From the process table entry d: tree size rts = {d[62:61], d[7:5]}, root index width = d[4:0], and root base = {d[55:8], 8'h00}.
- R4: A segment error ends the walk when EA bit 63 differs from EA bit 62, or when any of EA bits 61:31 is 1 at a position at or above bit 31+rts.
- R5: A root index width below 5, above 16, or above rts+19 ends the walk as a bad tree. Otherwise the working shift becomes rts+19 minus the root width. The segment error takes precedence.
- R6: Each directory entry address is {8'h00, B[55:19], (B[18:3] & ~k) | (x & k), 3'b000}. Here B is the level base, k has ones in its low (level width) bits, and x is the low 16 bits of EA[61:12] shifted right by the working shift.
- R7: A directory entry with bit 63 clear ends the walk with the invalid-entry error.
- R8: For a valid entry with bit 62 clear, the next width is bits 4:0. A width below 5, above 16, or above the working shift is a bad tree. Otherwise the shift is reduced by the width and the next base is {bits 55:8, 8'h00}.
- R9: A valid entry with bit 62 set completes the walk. The real address is {8'h00, (P[55:12] & ~f) | (EA[55:12] & f), P[11:0]}, where f has ones in its low (working shift) bits. The entry P itself is output as the leaf entry.
- R10: Only one memory read is outstanding. The request holds a stable, 8-byte-aligned address until it is acknowledged, and it drops in the cycle after the acknowledge.
- R11: done is a one-cycle pulse. In that cycle exactly one of done_ok, err_seg, err_invalid and err_badtree is 1, and all four are 0 outside it.
- R12: A start pulse while a walk is in progress is ignored and does not change that walk's result.
- R13: After reset the walker is idle, with no memory request and no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a walk (ignored unless idle) |
| ea_page | input | 52 | Effective address bits 63:12 |
| pid | input | 32 | Process ID register |
| ptab_base | input | 44 | Process table base, register bits 55:12 |
| ptab_size | input | 5 | Process table size field (PID index bits above 8) |
| mem_req | output | 1 | Memory read request, held until acknowledged |
| mem_addr | output | 64 | Byte address of the 8-byte entry |
| mem_ack | input | 1 | Read data valid, completes the request |
| mem_rdata | input | 64 | Entry read from memory |
| done | output | 1 | Walk finished (one cycle) |
| done_ok | output | 1 | Translation succeeded |
| err_seg | output | 1 | Segment check failed |
| err_invalid | output | 1 | Entry valid bit clear |
| err_badtree | output | 1 | Index width out of range |
| real_addr | output | 64 | Translated real address, meaningful with done_ok |
| leaf_pte | output | 64 | Leaf entry, meaningful with done_ok |

## Verification
The assertions check the port protocol on every cycle:
- a request holds its address until it is acknowledged;
- request addresses are aligned and below 2^56;
- a request drops after its acknowledge;
- done lasts one cycle, carries exactly one outcome flag, and no flag appears without done.

Only the directed scenarios can show that the arithmetic is right: the table and directory addresses built from masks, the PID override, the shift bookkeeping across several levels, the real address merge, and the choice among segment, invalid and bad-tree endings. They do this by comparing the logged read addresses and the final outputs against values derived by hand.

// File: rtl/rwalk_pkg.sv
package rwalk_pkg;

    localparam int VA_W    = 64;
    localparam int PAGE_W  = 52;   // EA bits 63:12
    localparam int PID_W   = 32;
    localparam int ENT_W   = 64;
    localparam int BASE_W  = 48;   // entry bits 55:8
    localparam int SHIFT_W = 7;
    localparam int SIZE_W  = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRTBL_READ,
        ST_SEG_CHECK,
        ST_LOOKUP,
        ST_WAIT_MEM,
        ST_FINISH
    } walk_state_e;

    typedef enum logic [1:0] {
        RES_OK,
        RES_SEG,
        RES_INVALID,
        RES_BADTREE
    } walk_result_e;

    // Run of n ones starting at bit 0 (saturates at 64)
    function automatic logic [63:0] low_ones(input logic [SHIFT_W-1:0] n);
        logic [63:0] m;
        for (int i = 0; i < 64; i++) begin
            m[i] = (i < int'(n));
        end
        return m;
    endfunction

endpackage

// File: rtl/rwalk_addr_gen.sv
module rwalk_addr_gen
    import rwalk_pkg::*;
(
    input  logic                 hv_mode,     // EA bit 63
    input  logic [49:0]          ea_idx,      // EA bits 61:12
    input  logic [PID_W-1:0]     pid,
    input  logic [43:0]          ptab_base,
    input  logic [4:0]           ptab_size,
    input  logic [BASE_W-1:0]    dir_base,    // level base bits 55:8
    input  logic [SIZE_W-1:0]    lvl_size,
    input  logic [SHIFT_W-1:0]   shift,
    output logic [VA_W-1:0]      tbl_addr,
    output logic [VA_W-1:0]      dir_addr
);
    logic [PID_W-1:0] eff_pid;
    logic [23:0]      pmask;
    logic [49:0]      shifted;
    logic [15:0]      idx16;
    logic [15:0]      kmask;
    logic [15:0]      base_lo;

    always_comb begin
        eff_pid  = hv_mode ? '0 : pid;
        pmask    = 24'(low_ones({2'b00, ptab_size}));
        tbl_addr = {8'h00, ptab_base[43:24],
                    (ptab_base[23:0] & ~pmask) | (eff_pid[31:8] & pmask),
                    eff_pid[7:0], 4'b0000};

        shifted  = ea_idx >> shift;
        idx16    = 16'(shifted);
        kmask    = 16'(low_ones({2'b00, lvl_size}));
        base_lo  = {dir_base[10:0], 5'b00000};   // base bits 18:3
        dir_addr = {8'h00, dir_base[47:11],
                    (base_lo & ~kmask) | (idx16 & kmask), 3'b000};
    end
endmodule

// File: rtl/rwalk_seg_check.sv
module rwalk_seg_check
    import rwalk_pkg::*;
#(
    parameter int MIN_LVL = 5,
    parameter int MAX_LVL = 16
) (
    input  logic [32:0]          ea_hi,       // EA bits 63:31
    input  logic [4:0]           rts,
    input  logic [SIZE_W-1:0]    root_size,
    output logic                 seg_fault,
    output logic                 size_bad,
    output logic [SHIFT_W-1:0]   start_shift
);
    localparam logic [SHIFT_W-1:0] MIN_V = SHIFT_W'(MIN_LVL);
    localparam logic [SHIFT_W-1:0] MAX_V = SHIFT_W'(MAX_LVL);

    logic [30:0]        fmask;
    logic [SHIFT_W-1:0] limit;
    logic [SHIFT_W-1:0] rsz;

    always_comb begin
        fmask       = 31'(low_ones({2'b00, rts}));
        seg_fault   = (ea_hi[32] ^ ea_hi[31]) | (|(ea_hi[30:0] & ~fmask));
        limit       = {2'b00, rts} + SHIFT_W'(19);
        rsz         = {2'b00, root_size};
        size_bad    = (rsz < MIN_V) || (rsz > MAX_V) || (rsz > limit);
        start_shift = limit - rsz;
    end
endmodule

// File: rtl/rwalk_entry_eval.sv
module rwalk_entry_eval
    import rwalk_pkg::*;
#(
    parameter int MIN_LVL = 5,
    parameter int MAX_LVL = 16
) (
    input  logic [55:0]          ent_body,    // entry bits 55:0
    input  logic [43:0]          ea_mid,      // EA bits 55:12
    input  logic [SHIFT_W-1:0]   shift,
    output logic                 next_bad,
    output logic [SIZE_W-1:0]    next_size,
    output logic [SHIFT_W-1:0]   next_shift,
    output logic [BASE_W-1:0]    next_base,
    output logic [VA_W-1:0]      real_addr
);
    localparam logic [SHIFT_W-1:0] MIN_V = SHIFT_W'(MIN_LVL);
    localparam logic [SHIFT_W-1:0] MAX_V = SHIFT_W'(MAX_LVL);

    logic [SHIFT_W-1:0] nsz;
    logic [43:0]        fmask;

    always_comb begin
        next_size  = ent_body[4:0];
        nsz        = {2'b00, next_size};
        next_bad   = (nsz < MIN_V) || (nsz > MAX_V) || (nsz > shift);
        next_shift = shift - nsz;
        next_base  = ent_body[55:8];
        fmask      = 44'(low_ones(shift));
        real_addr  = {8'h00, (ent_body[55:12] & ~fmask) | (ea_mid & fmask),
                      ent_body[11:0]};
    end
endmodule

// File: rtl/rwalk_top.sv
module rwalk_top
    import rwalk_pkg::*;
#(
    parameter int MIN_LVL = 5,
    parameter int MAX_LVL = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [PAGE_W-1:0]    ea_page,
    input  logic [PID_W-1:0]     pid,
    input  logic [43:0]          ptab_base,
    input  logic [4:0]           ptab_size,
    output logic                 mem_req,
    output logic [VA_W-1:0]      mem_addr,
    input  logic                 mem_ack,
    input  logic [ENT_W-1:0]     mem_rdata,
    output logic                 done,
    output logic                 done_ok,
    output logic                 err_seg,
    output logic                 err_invalid,
    output logic                 err_badtree,
    output logic [VA_W-1:0]      real_addr,
    output logic [ENT_W-1:0]     leaf_pte
);
    walk_state_e  state_q, state_d;
    walk_result_e result_q;

    logic [PAGE_W-1:0]  page_q;
    logic [PID_W-1:0]   pid_q;
    logic [43:0]        tbase_q;
    logic [4:0]         tsize_q;
    logic [4:0]         rts_q;
    logic [SIZE_W-1:0]  size_q;
    logic [SHIFT_W-1:0] shift_q;
    logic [BASE_W-1:0]  base_q;
    logic [VA_W-1:0]    addr_q;
    logic               root_rd_q;
    logic [VA_W-1:0]    real_q;
    logic [ENT_W-1:0]   pte_q;

    logic [VA_W-1:0]    tbl_addr, dir_addr;
    logic               seg_fault, size_bad;
    logic [SHIFT_W-1:0] start_shift;
    logic               next_bad;
    logic [SIZE_W-1:0]  next_size;
    logic [SHIFT_W-1:0] next_shift;
    logic [BASE_W-1:0]  next_base;
    logic [VA_W-1:0]    leaf_real;
    logic               ent_valid, ent_leaf;

    assign ent_valid = mem_rdata[63];
    assign ent_leaf  = mem_rdata[62];

    rwalk_addr_gen u_addr (
        .hv_mode   (page_q[51]),
        .ea_idx    (page_q[49:0]),
        .pid       (pid_q),
        .ptab_base (tbase_q),
        .ptab_size (tsize_q),
        .dir_base  (base_q),
        .lvl_size  (size_q),
        .shift     (shift_q),
        .tbl_addr  (tbl_addr),
        .dir_addr  (dir_addr)
    );

    rwalk_seg_check #(.MIN_LVL(MIN_LVL), .MAX_LVL(MAX_LVL)) u_seg (
        .ea_hi       (page_q[51:19]),
        .rts         (rts_q),
        .root_size   (size_q),
        .seg_fault   (seg_fault),
        .size_bad    (size_bad),
        .start_shift (start_shift)
    );

    rwalk_entry_eval #(.MIN_LVL(MIN_LVL), .MAX_LVL(MAX_LVL)) u_ent (
        .ent_body   (mem_rdata[55:0]),
        .ea_mid     (page_q[43:0]),
        .shift      (shift_q),
        .next_bad   (next_bad),
        .next_size  (next_size),
        .next_shift (next_shift),
        .next_base  (next_base),
        .real_addr  (leaf_real)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (start) state_d = ST_PRTBL_READ;
            ST_PRTBL_READ: state_d = ST_WAIT_MEM;
            ST_SEG_CHECK:  state_d = (seg_fault || size_bad) ? ST_FINISH : ST_LOOKUP;
            ST_LOOKUP:     state_d = ST_WAIT_MEM;
            ST_WAIT_MEM: begin
                if (mem_ack) begin
                    if (root_rd_q)                        state_d = ST_SEG_CHECK;
                    else if (!ent_valid || ent_leaf || next_bad) state_d = ST_FINISH;
                    else                                  state_d = ST_LOOKUP;
                end
            end
            ST_FINISH:     state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // State register and walk context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            result_q  <= RES_OK;
            page_q    <= '0;
            pid_q     <= '0;
            tbase_q   <= '0;
            tsize_q   <= '0;
            rts_q     <= '0;
            size_q    <= '0;
            shift_q   <= '0;
            base_q    <= '0;
            addr_q    <= '0;
            root_rd_q <= 1'b0;
            real_q    <= '0;
            pte_q     <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        page_q  <= ea_page;
                        pid_q   <= pid;
                        tbase_q <= ptab_base;
                        tsize_q <= ptab_size;
                    end
                end
                ST_PRTBL_READ: begin
                    addr_q    <= tbl_addr;
                    root_rd_q <= 1'b1;
                end
                ST_SEG_CHECK: begin
                    if (seg_fault)     result_q <= RES_SEG;
                    else if (size_bad) result_q <= RES_BADTREE;
                    else               shift_q  <= start_shift;
                end
                ST_LOOKUP: begin
                    addr_q    <= dir_addr;
                    root_rd_q <= 1'b0;
                end
                ST_WAIT_MEM: begin
                    if (mem_ack) begin
                        if (root_rd_q) begin
                            rts_q  <= {mem_rdata[62:61], mem_rdata[7:5]};
                            size_q <= mem_rdata[4:0];
                            base_q <= mem_rdata[55:8];
                        end else if (!ent_valid) begin
                            result_q <= RES_INVALID;
                        end else if (ent_leaf) begin
                            result_q <= RES_OK;
                            real_q   <= leaf_real;
                            pte_q    <= mem_rdata;
                        end else if (next_bad) begin
                            result_q <= RES_BADTREE;
                        end else begin
                            shift_q <= next_shift;
                            size_q  <= next_size;
                            base_q  <= next_base;
                        end
                    end
                end
                ST_FINISH: ;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_req     = (state_q == ST_WAIT_MEM);
        mem_addr    = addr_q;
        done        = (state_q == ST_FINISH);
        done_ok     = done && (result_q == RES_OK);
        err_seg     = done && (result_q == RES_SEG);
        err_invalid = done && (result_q == RES_INVALID);
        err_badtree = done && (result_q == RES_BADTREE);
        real_addr   = real_q;
        leaf_pte    = pte_q;
    end
endmodule

// File: rtl/rwalk_chk.sv
module rwalk_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req,
    input logic        mem_ack,
    input logic [63:0] mem_addr,
    input logic        done,
    input logic        done_ok,
    input logic        err_seg,
    input logic        err_invalid,
    input logic        err_badtree
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R10

    AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[2:0] == 3'b000 && mem_addr[63:56] == 8'h00)); // R10

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> !mem_req); // R10

    AST_DONE_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($countones({done_ok, err_seg, err_invalid, err_badtree}) == 1)); // R11

    AST_FLAGS_NEED_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ({done_ok, err_seg, err_invalid, err_badtree} == 4'b0000)); // R11

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_NO_REQ_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req); // R10
endmodule

bind rwalk_top rwalk_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_req     (mem_req),
    .mem_ack     (mem_ack),
    .mem_addr    (mem_addr),
    .done        (done),
    .done_ok     (done_ok),
    .err_seg     (err_seg),
    .err_invalid (err_invalid),
    .err_badtree (err_badtree)
);

// File: tb/tb_rwalk_top.sv
`timescale 1ns/1ps
module tb_rwalk_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [51:0] ea_page = '0;
    logic [31:0] pid = '0;
    logic [43:0] ptab_base = '0;
    logic [4:0]  ptab_size = '0;
    logic        mem_req;
    logic [63:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        done, done_ok, err_seg, err_invalid, err_badtree;
    logic [63:0] real_addr, leaf_pte;

    always #2.5 clk = ~clk;   // 200 MHz

    rwalk_top dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ea_page(ea_page), .pid(pid),
        .ptab_base(ptab_base), .ptab_size(ptab_size), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .done(done), .done_ok(done_ok), .err_seg(err_seg),
        .err_invalid(err_invalid), .err_badtree(err_badtree),
        .real_addr(real_addr), .leaf_pte(leaf_pte)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [63:0] mem_tbl [logic [63:0]];
    logic [63:0] rd_log [0:7];
    int          rd_cnt = 0;
    int          ack_delay = 0;
    int          wait_cnt = 0;

    logic [3:0]  got_flags;   // {ok, seg, invalid, badtree}
    logic [63:0] got_real, got_pte;

    localparam logic [63:0] PTE_LEAF = 64'hC000_0005_0000_0187;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Memory responder
    initial begin
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (wait_cnt < ack_delay) begin
                    wait_cnt++;
                end else begin
                    wait_cnt = 0;
                    mem_rdata = mem_tbl.exists(mem_addr) ? mem_tbl[mem_addr] : 64'h0;
                    if (rd_cnt < 8) rd_log[rd_cnt] = mem_addr;
                    rd_cnt++;
                    mem_ack = 1'b1;
                end
            end
        end
    end

    task automatic run_walk(input logic [63:0] ea, input logic [31:0] p,
                            input logic [43:0] tb, input logic [4:0] ts,
                            input bit poke_busy);
        int cnt;
        @(negedge clk);
        rd_cnt = 0;
        for (int i = 0; i < 8; i++) rd_log[i] = '0;
        ea_page = ea[63:12]; pid = p; ptab_base = tb; ptab_size = ts;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke_busy) begin
            repeat (2) @(negedge clk);
            ea_page = 52'h4_0000_0000_0000;   // would be a segment fault
            pid = 32'd5;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        cnt = 0;
        while (!done && cnt < 500) begin
            @(negedge clk);
            cnt++;
        end
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL R11: actual no done expected done");
        end
        got_flags = {done_ok, err_seg, err_invalid, err_badtree};
        got_real  = real_addr;
        got_pte   = leaf_pte;
        @(negedge clk);
        check("R11 done pulse width", {63'b0, done}, 64'd0);
        check("R11 flags after done", {60'b0, done_ok, err_seg, err_invalid, err_badtree}, 64'd0);
    endtask

    task automatic t_reset();
        check("R13 reset done", {63'b0, done}, 64'd0);
        check("R13 reset mem_req", {63'b0, mem_req}, 64'd0);
        check("R13 reset flags", {60'b0, done_ok, err_seg, err_invalid, err_badtree}, 64'd0);
    endtask

    task automatic t_basic();
        ack_delay = 2;
        run_walk(64'h1000, 32'd3, 44'h1000, 5'd0, 1'b0);
        check("R11 basic ok flag", {60'b0, got_flags}, 64'h8);
        check("R10 basic read count", 64'(rd_cnt), 64'd3);
        check("R1 basic table addr", rd_log[0], 64'h100_0030);
        check("R3 R6 root entry addr", rd_log[1], 64'h3_0000);
        check("R8 second level addr", rd_log[2], 64'h4_0000);
        check("R9 real address", got_real, 64'h5_0000_1187);
        check("R9 leaf entry", got_pte, PTE_LEAF);
    endtask

    task automatic t_index();
        ack_delay = 0;
        run_walk(64'h100_C000_5ABC, 32'd3, 44'h1000, 5'd0, 1'b0);
        check("R6 root index merge", rd_log[1], 64'h3_0010);
        check("R8 second index merge", rd_log[2], 64'h4_0018);
        check("R9 real address merge", got_real, 64'h5_0000_5187);
        check("R11 index ok flag", {60'b0, got_flags}, 64'h8);
    endtask

    task automatic t_hv_pid();
        ack_delay = 1;
        run_walk(64'hC000_0000_0000_1000, 32'd3, 44'h1000, 5'd0, 1'b0);
        check("R2 pid forced to zero", rd_log[0], 64'h100_0000);
        check("R2 walk completes", {60'b0, got_flags}, 64'h8);
    endtask

    task automatic t_ptab_size();
        ack_delay = 0;
        run_walk(64'h1000, 32'h1234, 44'h1000, 5'd4, 1'b0);
        check("R1 table size mask merge", rd_log[0], 64'h100_2340);
    endtask

    task automatic t_segment();
        ack_delay = 0;
        run_walk(64'h4000_0000_0000_0000, 32'd3, 44'h1000, 5'd0, 1'b0);
        check("R4 bit63 vs bit62", {60'b0, got_flags}, 64'h4);
        check("R4 one read only", 64'(rd_cnt), 64'd1);
        run_walk(64'h0080_0000_0000_0000, 32'd3, 44'h1000, 5'd0, 1'b0);
        check("R4 bit above tree size", {60'b0, got_flags}, 64'h4);
        run_walk(64'h0008_0000_0000_0000, 32'd3, 44'h1000, 5'd0, 1'b0);
        check("R4 top in-range bit passes", {60'b0, got_flags}, 64'h2);
        check("R6 top root index bit", rd_log[1], 64'h3_8000);
    endtask

    task automatic t_invalid();
        ack_delay = 0;
        run_walk(64'h80_0000_0000, 32'd3, 44'h1000, 5'd0, 1'b0);
        check("R7 invalid entry", {60'b0, got_flags}, 64'h2);
        check("R7 two reads", 64'(rd_cnt), 64'd2);
    endtask

    task automatic t_badtree();
        ack_delay = 0;
        run_walk(64'h1000, 32'd5, 44'h1000, 5'd0, 1'b0);
        check("R5 root width below min", {60'b0, got_flags}, 64'h1);
        check("R5 no directory read", 64'(rd_cnt), 64'd1);
        run_walk(64'h0, 32'd6, 44'h1000, 5'd0, 1'b0);
        check("R8 width above max", {60'b0, got_flags}, 64'h1);
        check("R8 stops after bad entry", 64'(rd_cnt), 64'd2);
        run_walk(64'h80_0000_0000, 32'd6, 44'h1000, 5'd0, 1'b0);
        check("R8 shift reduced by 16", rd_log[3], 64'h8_0000);
        check("R8 width above shift", {60'b0, got_flags}, 64'h1);
    endtask

    task automatic t_busy();
        ack_delay = 2;
        run_walk(64'h1000, 32'd3, 44'h1000, 5'd0, 1'b1);
        check("R12 result unchanged", {60'b0, got_flags}, 64'h8);
        check("R12 real unchanged", got_real, 64'h5_0000_1187);
        check("R12 no extra reads", 64'(rd_cnt), 64'd3);
    endtask

    initial begin
        mem_tbl[64'h100_0030] = 64'h4000_0000_0003_00AD;  // pid 3
        mem_tbl[64'h100_0000] = 64'h4000_0000_0003_00AD;  // pid 0
        mem_tbl[64'h100_2340] = 64'h4000_0000_0003_00AD;  // sized table
        mem_tbl[64'h100_0050] = 64'h4000_0000_0003_00A4;  // root width 4
        mem_tbl[64'h100_0060] = 64'h4000_0000_0006_00AD;  // pid 6 tree
        mem_tbl[64'h3_0000]   = 64'h8000_0000_0004_0009;
        mem_tbl[64'h3_0010]   = 64'h8000_0000_0004_0009;
        mem_tbl[64'h4_0000]   = PTE_LEAF;
        mem_tbl[64'h4_0018]   = PTE_LEAF;
        mem_tbl[64'h6_0000]   = 64'h8000_0000_0007_0011;  // width 17
        mem_tbl[64'h6_0008]   = 64'h8000_0000_0007_0009;
        mem_tbl[64'h7_0000]   = 64'h8000_0000_0008_0010;  // width 16
        mem_tbl[64'h8_0000]   = 64'h8000_0000_0009_0005;  // width 5 > shift 2

        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_basic();
        t_index();
        t_hv_pid();
        t_ptab_size();
        t_segment();
        t_invalid();
        t_badtree();
        t_busy();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule